// File: doc/BRIEF.md
# Interrupt Source Configuration and Routing

This block keeps the configuration for a small bank of interrupt inputs and decides, cycle by cycle, when each input is handed to the processor ports that should see it. Every source owns two 32-bit words: a vector/priority word, which holds a mask bit, a read-only activity flag, a sense bit, a 5-bit priority and a vector, and a destination word that selects processor ports. Both words are reached through a simple synchronous register port.

A source that is pending, unmasked, of nonzero priority, not already active and with a nonzero destination word is offered to every destination whose bit it sets. A destination accepts it only when the priority is strictly above that destination's current task priority. When a destination accepts, it emits a one-cycle raise pulse that carries the source index and priority, and the source's activity flag is set. The flag then blocks any further delivery until a level input drops or, for an edge source, an acknowledge arrives.

Top module: `irq_src_router`

## Requirements
- R1: After reset every vector/priority word reads 0xA0000000 (bit 31 mask set), every destination word reads 0 and no raise output is valid.
- R2: A register write to word 2*s (source s, vector/priority) stores all written bits except bit 30; bit 30 on read reflects the activity flag. Read data appears on the cycle after the address is presented.
- R3: A write to word 2*s+1 (destination) keeps only bits 31:30 and bits NUM_DST-1:0; all other bits read back as 0.
- R4: A source whose mask bit 31 is set is never forwarded. A pending edge held while masked is forwarded once the mask is cleared by a write.
- R5: A source whose priority field (bits 20:16) is zero is never forwarded; a write giving it a nonzero priority forwards a held edge.
- R6: A source whose destination word is zero is not forwarded.
- R7: With sense bit 22 set (level), the source is pending while its input is high; forwarding sets the activity flag, and a low input clears the flag so that a new high level is forwarded again.
- R8: With bit 22 clear (edge), a rising input sets pending; forwarding consumes it. An edge arriving while the flag is set is held and delivered after an acknowledge clears the flag; a second acknowledge without a new edge causes no delivery.
- R9: An acknowledge addressed to a level source has no effect on its activity flag.
- R10: A destination receives a source only when the source priority is strictly greater than that destination's task priority; a source accepted nowhere stays pending with its flag clear and is delivered once the task priority drops below it.
- R11: Every destination whose bit is set receives the source in the same cycle.
- R12: When several sources compete for one destination, the highest priority wins and ties go to the lower index; losers are delivered in later cycles.
- R13: Each delivery is a raise pulse lasting exactly one cycle, registered one clock after the source becomes eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | SRC_W+1 | Word address: {source index, word select} |
| regWe | input | 1 | Register write enable |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for the previous cycle's address |
| irqIn | input | NUM_SRC | Interrupt inputs |
| taskPrio | input | NUM_DST*TASK_W | Current task priority per destination |
| ackValid | input | 1 | Acknowledge strobe |
| ackIdx | input | SRC_W | Source being acknowledged |
| raiseValid | output | NUM_DST | One-cycle raise pulse per destination |
| raiseIdx | output | NUM_DST*SRC_W | Source index carried by each raise |
| raisePrio | output | NUM_DST*5 | Priority carried by each raise |

## Verification
The routing decision is exercised with a level source held high across several configuration changes, edge pulses that land while the source is masked, at zero priority or already active, and two sources asserted in the same cycle toward one destination. The masked and zero-priority pulses separate a design that drops an edge from one that holds it until the gate opens. Simultaneous requests at equal and at unequal priority tell the priority order apart from the index order, and moving the task priority across the source priority distinguishes a strict comparison from an inclusive one.

// File: rtl/irq_src_router_pkg.sv
package irq_src_router_pkg;
  localparam int IDX_MAX_W = 8;
  localparam int MASK_BIT  = 31;
  localparam int ACT_BIT   = 30;
  localparam int SENSE_BIT = 22;
  localparam int PRIO_LSB  = 16;
  localparam int PRIO_W    = 5;
  localparam logic [31:0] VP_RST = 32'hA000_0000;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrVp;
    logic                 wrDst;
    logic [IDX_MAX_W-1:0] wrIdx;
    logic                 ackEn;
    logic [IDX_MAX_W-1:0] ackIdx;
    logic                 rdHit;
    logic                 rdDst;
    logic [IDX_MAX_W-1:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/irq_src_router_ctrl.sv
module irq_src_router_ctrl
  import irq_src_router_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = SRC_W + 1
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              ackValid,
  input  logic [SRC_W-1:0]  ackIdx,
  output strobe_t           strb
);
  logic [SRC_W-1:0] fieldIdx;
  logic             inRange;
  logic             ackInRange;

  assign fieldIdx   = regAddr[ADDR_W-1:1];
  assign inRange    = (int'(fieldIdx) < NUM_SRC);
  assign ackInRange = (int'(ackIdx) < NUM_SRC);

  always_comb begin
    strb        = '0;
    strb.wrIdx  = IDX_MAX_W'(fieldIdx);
    strb.rdIdx  = IDX_MAX_W'(fieldIdx);
    strb.ackIdx = IDX_MAX_W'(ackIdx);
    strb.wrVp   = regWe && inRange && !regAddr[0];
    strb.wrDst  = regWe && inRange && regAddr[0];
    strb.rdHit  = inRange;
    strb.rdDst  = regAddr[0];
    strb.ackEn  = ackValid && ackInRange;
  end
endmodule

// File: rtl/irq_src_router_dp.sv
module irq_src_router_dp
  import irq_src_router_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_DST = 2,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [31:0]                 wdata,
  input  logic [NUM_SRC-1:0]          irqIn,
  input  logic [NUM_SRC-1:0]          won,
  output logic [NUM_SRC-1:0]          eligible,
  output logic [NUM_SRC*PRIO_W-1:0]   prioVec,
  output logic [NUM_SRC*NUM_DST-1:0]  dstVec,
  output logic [31:0]                 rdata
);
  localparam logic [31:0] DST_KEEP = 32'hC000_0000 | ((32'd1 << NUM_DST) - 32'd1);
  localparam logic [31:0] ACT_CLR  = ~(32'd1 << ACT_BIT);

  logic [31:0] vpView  [NUM_SRC];
  logic [31:0] dstView [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [31:0] vpQ;
    logic [31:0] dstQ;
    logic        actQ;
    logic        pendEdgeQ;
    logic        irqPrevQ;
    logic        sense;
    logic        pendNow;
    logic        wrVpHit;
    logic        wrDstHit;
    logic        ackHit;

    assign sense    = vpQ[SENSE_BIT];
    assign pendNow  = sense ? irqIn[s] : pendEdgeQ;
    assign wrVpHit  = strb.wrVp  && (strb.wrIdx  == IDX_MAX_W'(s));
    assign wrDstHit = strb.wrDst && (strb.wrIdx  == IDX_MAX_W'(s));
    assign ackHit   = strb.ackEn && (strb.ackIdx == IDX_MAX_W'(s));

    assign eligible[s] = pendNow && !vpQ[MASK_BIT] &&
                         (vpQ[PRIO_LSB +: PRIO_W] != '0) &&
                         !actQ && (dstQ != '0);
    assign prioVec[s*PRIO_W +: PRIO_W]   = vpQ[PRIO_LSB +: PRIO_W];
    assign dstVec[s*NUM_DST +: NUM_DST]  = dstQ[NUM_DST-1:0];
    assign vpView[s]  = (vpQ & ACT_CLR) | (32'(actQ) << ACT_BIT);
    assign dstView[s] = dstQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vpQ       <= VP_RST;
        dstQ      <= '0;
        actQ      <= 1'b0;
        pendEdgeQ <= 1'b0;
        irqPrevQ  <= 1'b0;
      end else begin
        irqPrevQ <= irqIn[s];
        if (irqIn[s] && !irqPrevQ) pendEdgeQ <= 1'b1;
        else if (won[s])           pendEdgeQ <= 1'b0;

        if (sense && !irqIn[s])    actQ <= 1'b0;
        else if (ackHit && !sense) actQ <= 1'b0;
        else if (won[s])           actQ <= 1'b1;

        if (wrVpHit)  vpQ  <= wdata & ACT_CLR;
        if (wrDstHit) dstQ <= wdata & DST_KEEP;
      end
    end
  end

  logic [SRC_W-1:0] rdSel;
  assign rdSel = strb.rdIdx[SRC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)           rdata <= '0;
    else if (!strb.rdHit) rdata <= '0;
    else if (strb.rdDst) rdata <= dstView[rdSel];
    else                 rdata <= vpView[rdSel];
  end
endmodule

// File: rtl/irq_src_router_arb.sv
module irq_src_router_arb
  import irq_src_router_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_DST = 2,
  parameter int TASK_W  = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          eligible,
  input  logic [NUM_SRC*PRIO_W-1:0]   prioVec,
  input  logic [NUM_SRC*NUM_DST-1:0]  dstVec,
  input  logic [NUM_DST*TASK_W-1:0]   taskPrio,
  output logic [NUM_SRC-1:0]          won,
  output logic [NUM_DST-1:0]          raiseValid,
  output logic [NUM_DST*SRC_W-1:0]    raiseIdx,
  output logic [NUM_DST*PRIO_W-1:0]   raisePrio
);
  logic [NUM_DST-1:0] hitV;
  logic [SRC_W-1:0]   hitI [NUM_DST];

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    logic [PRIO_W-1:0] taskExt;
    logic              bestV;
    logic [SRC_W-1:0]  bestI;
    logic [PRIO_W-1:0] bestP;
    logic              validQ;
    logic [SRC_W-1:0]  idxQ;
    logic [PRIO_W-1:0] prioQ;

    assign taskExt = PRIO_W'(taskPrio[d*TASK_W +: TASK_W]);

    // highest priority wins; strict compare keeps the lower index on ties
    always_comb begin
      bestV = 1'b0;
      bestI = '0;
      bestP = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (eligible[s] && dstVec[s*NUM_DST + d] &&
            (prioVec[s*PRIO_W +: PRIO_W] > taskExt) &&
            (!bestV || (prioVec[s*PRIO_W +: PRIO_W] > bestP))) begin
          bestV = 1'b1;
          bestI = SRC_W'(s);
          bestP = prioVec[s*PRIO_W +: PRIO_W];
        end
      end
    end

    assign hitV[d] = bestV;
    assign hitI[d] = bestI;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        idxQ   <= '0;
        prioQ  <= '0;
      end else begin
        validQ <= bestV;
        idxQ   <= bestV ? bestI : '0;
        prioQ  <= bestV ? bestP : '0;
      end
    end

    assign raiseValid[d]                = validQ;
    assign raiseIdx[d*SRC_W +: SRC_W]   = idxQ;
    assign raisePrio[d*PRIO_W +: PRIO_W] = prioQ;
  end

  always_comb begin
    won = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int d = 0; d < NUM_DST; d++) begin
        if (hitV[d] && (hitI[d] == SRC_W'(s))) won[s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
  import irq_src_router_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_DST = 2,
  parameter int TASK_W  = 4,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = SRC_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic                       regWe,
  input  logic [31:0]                regWdata,
  output logic [31:0]                regRdata,
  input  logic [NUM_SRC-1:0]         irqIn,
  input  logic [NUM_DST*TASK_W-1:0]  taskPrio,
  input  logic                       ackValid,
  input  logic [SRC_W-1:0]           ackIdx,
  output logic [NUM_DST-1:0]         raiseValid,
  output logic [NUM_DST*SRC_W-1:0]   raiseIdx,
  output logic [NUM_DST*PRIO_W-1:0]  raisePrio
);
  strobe_t                    strb;
  logic [NUM_SRC-1:0]         eligible;
  logic [NUM_SRC-1:0]         won;
  logic [NUM_SRC*PRIO_W-1:0]  prioVec;
  logic [NUM_SRC*NUM_DST-1:0] dstVec;

  irq_src_router_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .ackValid(ackValid),
    .ackIdx  (ackIdx),
    .strb    (strb)
  );

  irq_src_router_dp #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (regWdata),
    .irqIn   (irqIn),
    .won     (won),
    .eligible(eligible),
    .prioVec (prioVec),
    .dstVec  (dstVec),
    .rdata   (regRdata)
  );

  irq_src_router_arb #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .TASK_W(TASK_W)) u_arb (
    .clk       (clk),
    .rstN      (rstN),
    .eligible  (eligible),
    .prioVec   (prioVec),
    .dstVec    (dstVec),
    .taskPrio  (taskPrio),
    .won       (won),
    .raiseValid(raiseValid),
    .raiseIdx  (raiseIdx),
    .raisePrio (raisePrio)
  );
endmodule

// File: rtl/irq_src_router_chk.sv
module irq_src_router_chk #(
  parameter int NUM_SRC = 4,
  parameter int NUM_DST = 2,
  parameter int TASK_W  = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_DST*TASK_W-1:0] taskPrio,
  input logic [NUM_DST-1:0]        raiseValid,
  input logic [NUM_DST*SRC_W-1:0]  raiseIdx,
  input logic [NUM_DST*5-1:0]      raisePrio
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (raiseValid == '0));

  for (genvar d = 0; d < NUM_DST; d++) begin : g_chk
    // R5
    prio_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
      raiseValid[d] |-> (raisePrio[d*5 +: 5] != '0));

    // R10
    above_task_chk: assert property (@(posedge clk) disable iff (!rstN)
      raiseValid[d] |-> (raisePrio[d*5 +: 5] > 5'($past(taskPrio[d*TASK_W +: TASK_W]))));

    // R13
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      raiseValid[d] |=> !(raiseValid[d] &&
                          (raiseIdx[d*SRC_W +: SRC_W] == $past(raiseIdx[d*SRC_W +: SRC_W]))));
  end
endmodule

bind irq_src_router irq_src_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .TASK_W(TASK_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .taskPrio  (taskPrio),
  .raiseValid(raiseValid),
  .raiseIdx  (raiseIdx),
  .raisePrio (raisePrio)
);

// File: tb/irq_src_router_tb.sv
module irq_src_router_tb;
  localparam int NS = 4;
  localparam int ND = 2;
  localparam int TW = 4;
  localparam int SW = 2;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0]    regAddr = '0;
  logic             regWe = 1'b0;
  logic [31:0]      regWdata = '0;
  logic [31:0]      regRdata;
  logic [NS-1:0]    irqIn = '0;
  logic [ND*TW-1:0] taskPrio = '0;
  logic             ackValid = 1'b0;
  logic [SW-1:0]    ackIdx = '0;
  logic [ND-1:0]    raiseValid;
  logic [ND*SW-1:0] raiseIdx;
  logic [ND*5-1:0]  raisePrio;

  irq_src_router #(.NUM_SRC(NS), .NUM_DST(ND), .TASK_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irqIn(irqIn),
    .taskPrio(taskPrio), .ackValid(ackValid), .ackIdx(ackIdx),
    .raiseValid(raiseValid), .raiseIdx(raiseIdx), .raisePrio(raisePrio)
  );

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  logic [31:0] mVp [NS];
  logic [31:0] mDst [NS];
  bit          mAct [NS];
  bit          mPend [NS];
  bit          mPrev [NS];
  bit          eV [ND];
  int          eI [ND];
  int          eP [ND];
  logic [31:0] eRd;
  int          saw [ND][NS];
  int          order0 [$];

  function automatic void check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  always @(posedge clk) begin : model
    bit won [NS];
    bit el [NS];
    bit lvl, pn, bv;
    int bi, bp, pr, tp, si;
    if (!rstN) begin
      for (int s = 0; s < NS; s++) begin
        mVp[s] = 32'hA000_0000; mDst[s] = 0; mAct[s] = 0; mPend[s] = 0; mPrev[s] = 0;
      end
      for (int d = 0; d < ND; d++) begin eV[d] = 0; eI[d] = 0; eP[d] = 0; end
      eRd = 0;
    end else begin
      for (int s = 0; s < NS; s++) begin
        lvl = mVp[s][22];
        pn = lvl ? irqIn[s] : mPend[s];
        el[s] = pn && !mVp[s][31] && (mVp[s][20:16] != 0) && !mAct[s] && (mDst[s] != 0);
        won[s] = 0;
      end
      for (int d = 0; d < ND; d++) begin
        bv = 0; bi = 0; bp = 0;
        tp = int'(taskPrio[d*TW +: TW]);
        for (int s = 0; s < NS; s++) begin
          pr = int'(mVp[s][20:16]);
          if (el[s] && mDst[s][d] && pr > tp && (!bv || pr > bp)) begin
            bv = 1; bi = s; bp = pr;
          end
        end
        eV[d] = bv; eI[d] = bi; eP[d] = bp;
        if (bv) won[bi] = 1;
      end
      si = int'(regAddr) / 2;
      if (regAddr[0]) eRd = mDst[si];
      else            eRd = (mVp[si] & ~32'h4000_0000) | (mAct[si] ? 32'h4000_0000 : 0);
      for (int s = 0; s < NS; s++) begin
        lvl = mVp[s][22];
        if (lvl && !irqIn[s])                            mAct[s] = 0;
        else if (ackValid && int'(ackIdx) == s && !lvl)  mAct[s] = 0;
        else if (won[s])                                 mAct[s] = 1;
        if (irqIn[s] && !mPrev[s]) mPend[s] = 1;
        else if (won[s])           mPend[s] = 0;
        mPrev[s] = irqIn[s];
      end
      if (regWe) begin
        if (regAddr[0]) mDst[si] = regWdata & 32'hC000_0003;
        else            mVp[si]  = regWdata & ~32'h4000_0000;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int d = 0; d < ND; d++) begin
        check(raiseValid[d] == eV[d], curReq, "raise valid", raiseValid[d], eV[d]);
        if (raiseValid[d] && eV[d]) begin
          check(int'(raiseIdx[d*SW +: SW]) == eI[d], curReq, "raise index", raiseIdx[d*SW +: SW], eI[d]);
          check(int'(raisePrio[d*5 +: 5]) == eP[d], curReq, "raise priority", raisePrio[d*5 +: 5], eP[d]);
        end
        if (raiseValid[d]) begin
          saw[d][raiseIdx[d*SW +: SW]]++;
          if (d == 0) order0.push_back(int'(raiseIdx[SW-1:0]));
        end
      end
      check(regRdata == eRd, curReq, "read data", regRdata, eRd);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] v);
    @(negedge clk);
    regAddr = AW'(a); regWe = 1'b1; regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(int a, logic [31:0] exp, string req);
    @(negedge clk);
    regAddr = AW'(a);
    @(negedge clk);
    check(regRdata == exp, req, "register readback", regRdata, exp);
  endtask

  task automatic ack(int s);
    @(negedge clk);
    ackValid = 1'b1; ackIdx = SW'(s);
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic setIrq(int s, bit v);
    @(negedge clk);
    irqIn[s] = v;
  endtask

  task automatic pulse(int s);
    setIrq(s, 1'b1);
    setIrq(s, 1'b0);
  endtask

  task automatic sawChk(int d, int s, int exp, string req);
    check(saw[d][s] == exp, req, "raise count", saw[d][s], exp);
  endtask

  initial begin
    for (int d = 0; d < ND; d++) for (int s = 0; s < NS; s++) saw[d][s] = 0;
    tick(4);
    rstN = 1'b1;
    @(negedge clk);
    check(raiseValid == '0, "R1", "raise after reset", raiseValid, 0);
    rdChk(0, 32'hA000_0000, "R1");
    rdChk(7, 32'h0000_0000, "R1");

    curReq = "R2";
    wr(0, 32'h4045_0011);
    rdChk(0, 32'h0045_0011, "R2");

    curReq = "R3";
    wr(1, 32'hFFFF_FFFF);
    rdChk(1, 32'hC000_0003, "R3");
    wr(1, 32'h0);
    rdChk(1, 32'h0, "R3");

    curReq = "R6";
    setIrq(0, 1'b1);
    tick(4);
    sawChk(0, 0, 0, "R6");

    curReq = "R7";
    wr(1, 32'h1);
    tick(4);
    sawChk(0, 0, 1, "R7");
    rdChk(0, 32'h4045_0011, "R7");
    setIrq(0, 1'b0);
    tick(2);
    rdChk(0, 32'h0045_0011, "R7");
    setIrq(0, 1'b1);
    tick(4);
    sawChk(0, 0, 2, "R7");

    curReq = "R9";
    ack(0);
    tick(3);
    sawChk(0, 0, 2, "R9");
    rdChk(0, 32'h4045_0011, "R9");
    setIrq(0, 1'b0);
    tick(2);

    curReq = "R4";
    wr(2, 32'h8005_0022);
    wr(3, 32'h3);
    pulse(1);
    tick(4);
    sawChk(0, 1, 0, "R4");
    sawChk(1, 1, 0, "R4");

    curReq = "R11";
    wr(2, 32'h0005_0022);
    tick(4);
    sawChk(0, 1, 1, "R11");
    sawChk(1, 1, 1, "R11");
    rdChk(2, 32'h4005_0022, "R11");

    curReq = "R8";
    pulse(1);
    tick(4);
    sawChk(0, 1, 1, "R8");
    ack(1);
    tick(4);
    sawChk(0, 1, 2, "R8");
    ack(1);
    tick(4);
    sawChk(0, 1, 2, "R8");
    rdChk(2, 32'h0005_0022, "R8");

    curReq = "R5";
    wr(4, 32'h0000_0033);
    wr(5, 32'h1);
    pulse(2);
    tick(4);
    sawChk(0, 2, 0, "R5");
    wr(4, 32'h0003_0033);
    tick(4);
    sawChk(0, 2, 1, "R5");
    ack(2);

    curReq = "R10";
    @(negedge clk) taskPrio[3:0] = 4'd6;
    wr(6, 32'h0046_0044);
    wr(7, 32'h1);
    setIrq(3, 1'b1);
    tick(4);
    sawChk(0, 3, 0, "R10");
    rdChk(6, 32'h0046_0044, "R10");
    @(negedge clk) taskPrio[3:0] = 4'd5;
    tick(4);
    sawChk(0, 3, 1, "R10");
    setIrq(3, 1'b0);
    @(negedge clk) taskPrio = '0;
    tick(2);

    curReq = "R12";
    wr(4, 32'h0045_0033);
    tick(1);
    order0.delete();
    @(negedge clk) begin irqIn[0] = 1'b1; irqIn[2] = 1'b1; end
    tick(5);
    check(order0.size() == 2, "R13", "pulses on tie", order0.size(), 2);
    if (order0.size() == 2) begin
      check(order0[0] == 0, "R12", "tie winner", order0[0], 0);
      check(order0[1] == 2, "R12", "tie loser later", order0[1], 2);
    end
    @(negedge clk) begin irqIn[0] = 1'b0; irqIn[2] = 1'b0; end
    tick(2);
    wr(4, 32'h0049_0033);
    tick(1);
    order0.delete();
    @(negedge clk) begin irqIn[0] = 1'b1; irqIn[2] = 1'b1; end
    tick(5);
    check(order0.size() == 2, "R13", "pulses on priority race", order0.size(), 2);
    if (order0.size() == 2) begin
      check(order0[0] == 2, "R12", "higher priority first", order0[0], 2);
      check(order0[1] == 0, "R12", "lower priority later", order0[1], 0);
    end
    @(negedge clk) begin irqIn[0] = 1'b0; irqIn[2] = 1'b0; end
    tick(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule